// File: doc/BRIEF.md
# Compare-Alarm Cycle Timer

This block is a free-running cycle counter with a single one-shot compare alarm. The counter advances by one on every clock and wraps from its all-ones value back to zero. `count_o` is a register, so a user can read it directly as a timestamp.

The alarm is controlled through three request pins. A schedule request loads an absolute target and arms the alarm. A cancel request disarms it. A move request swaps the pending target for a new one and leaves the alarm armed. Each schedule or move also captures a match mode: exact equality, or greater-or-equal.

When the match condition holds, the block emits a one-cycle pulse on `alarm_o`. It then drops back to the disarmed state and sets a sticky `fired_o` flag.

Timing is stated in terms of `count_o`. A match is detected on the clock edge that ends a cycle in which `count_o` satisfies the condition. The pulse is therefore visible in the next cycle, when `count_o` already shows target+1.

Top module: `cyc_alarm_timer`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active-high), the block is cleared: `count_o`=0, `alarm_o`=0, `armed_o`=0 and `fired_o`=0.
- R2: Out of reset, `count_o` increases by exactly one per cycle modulo 2**WIDTH, so 2**WIDTH-1 is followed by 0.
- R3: In equality mode (`mode_i`=0 at schedule), the alarm fires on the edge that ends the cycle in which `count_o` equals the target. `alarm_o` is high in the following cycle.
- R4: A schedule whose target equals the `count_o` value present in the scheduling cycle fires on that same edge. The alarm does not wait for a wrap.
- R5: In equality mode, a target numerically below the current count fires only after the counter wraps and reaches the target. This takes ((target-count) mod 2**WIDTH)+1 cycles from the scheduling cycle.
- R6: In greater-or-equal mode (`mode_i`=1 at schedule or move), the alarm fires on the first cycle in which `count_o` is at or above the threshold. If the count is already at or above the threshold when scheduled, it fires immediately.
- R7: A cancel request disarms a pending alarm, so it never fires. `armed_o` is 0 after the cancel edge.
- R8: A move request while armed replaces the target and mode, takes effect from the next cycle and keeps `armed_o` at 1. A move request while disarmed has no effect.
- R9: Request priority is cancel, then schedule, then move. Any request present in a cycle where the pending alarm would match suppresses that cycle's pulse.
- R10: `alarm_o` lasts for the cycle after a match and is never high together with `armed_o`. After firing, the alarm stays disarmed until scheduled again.
- R11: `fired_o` rises with the first alarm pulse and then remains high until reset. It stays 0 while no pulse has occurred.
- R12: `armed_o` is 1 exactly while an alarm is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_i | input | 1 | Schedule request: load target and mode, arm |
| cancel_i | input | 1 | Cancel request: disarm |
| move_i | input | 1 | Move request: new target and mode while armed |
| target_i | input | WIDTH | Absolute target or threshold for schedule/move |
| mode_i | input | 1 | Match mode for schedule/move: 0 equality, 1 greater-or-equal |
| count_o | output | WIDTH | Registered free-running count |
| alarm_o | output | 1 | One-cycle alarm pulse |
| armed_o | output | 1 | Alarm pending |
| fired_o | output | 1 | Sticky: alarm has fired at least once |

## Verification
The bound checker watches several properties on every cycle:
- the count steps by one with modular wrap;
- `fired_o` never falls;
- a pulse never coincides with `armed_o`;
- every pulse is preceded by a pending alarm or a schedule;
- a cancel always leaves the block disarmed;
- a move while armed keeps it armed.

Other behaviours can only be shown by the directed scenarios, because each depends on a chosen target and the exact cycle of firing. These cover exact cycle counts to the pulse for future, equal and already-passed targets, the difference between the two match modes, and the suppression of a pulse by a cancel or move in the match cycle. They also cover the absence of any pulse after a cancel or an idle move.

// File: rtl/cyc_alarm_pkg.sv
package cyc_alarm_pkg;

  typedef enum logic {
    MATCH_EQ = 1'b0,
    MATCH_GE = 1'b1
  } match_mode_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_CANCEL = 2'd1,
    CMD_SCHED  = 2'd2,
    CMD_MOVE   = 2'd3
  } alarm_cmd_e;

  // Request priority: cancel over schedule over move; move needs a pending alarm
  function automatic alarm_cmd_e pick_cmd(input logic sched, input logic cancel,
                                          input logic move, input logic armed);
    alarm_cmd_e c;
    if (cancel)              c = CMD_CANCEL;
    else if (sched)          c = CMD_SCHED;
    else if (move && armed)  c = CMD_MOVE;
    else                     c = CMD_NONE;
    return c;
  endfunction

endpackage

// File: rtl/cyc_free_counter.sv
module cyc_free_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count_q
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + STEP;
  end

endmodule

// File: rtl/cyc_match_unit.sv
module cyc_match_unit
  import cyc_alarm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter bit GE_EN = 1'b1
) (
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] target,
  input  match_mode_e      mode,
  output logic             hit
);

  logic eq_hit;
  assign eq_hit = (count == target);

  generate
    if (GE_EN) begin : g_with_ge
      logic ge_hit;
      assign ge_hit = (count >= target);
      assign hit    = (mode == MATCH_GE) ? ge_hit : eq_hit;
    end else begin : g_eq_only
      assign hit = eq_hit;
    end
  endgenerate

endmodule

// File: rtl/cyc_alarm_ctrl.sv
module cyc_alarm_ctrl
  import cyc_alarm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter bit GE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sched,
  input  logic             cancel,
  input  logic             move,
  input  logic [WIDTH-1:0] new_target,
  input  match_mode_e      new_mode,
  input  logic [WIDTH-1:0] count,
  output logic             alarm_q,
  output logic             armed_q,
  output logic             fired_q
);

  logic [WIDTH-1:0] target_q;
  match_mode_e      mode_q;
  match_mode_e      mode_in;
  alarm_cmd_e       cmd;
  logic             pend_hit;
  logic             imm_hit;

  assign mode_in = GE_EN ? new_mode : MATCH_EQ;
  assign cmd     = pick_cmd(sched, cancel, move, armed_q);

  // Compare of the stored target against the running count
  cyc_match_unit #(.WIDTH(WIDTH), .GE_EN(GE_EN)) u_pend_match (
    .count  (count),
    .target (target_q),
    .mode   (mode_q),
    .hit    (pend_hit)
  );

  // Compare of an incoming schedule target, for an at-once match
  cyc_match_unit #(.WIDTH(WIDTH), .GE_EN(GE_EN)) u_imm_match (
    .count  (count),
    .target (new_target),
    .mode   (mode_in),
    .hit    (imm_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      mode_q   <= MATCH_EQ;
      armed_q  <= 1'b0;
      alarm_q  <= 1'b0;
      fired_q  <= 1'b0;
    end else begin
      alarm_q <= 1'b0;
      unique case (cmd)
        CMD_CANCEL: armed_q <= 1'b0;
        CMD_SCHED: begin
          target_q <= new_target;
          mode_q   <= mode_in;
          if (imm_hit) begin
            alarm_q <= 1'b1;
            fired_q <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            armed_q <= 1'b1;
          end
        end
        CMD_MOVE: begin
          target_q <= new_target;
          mode_q   <= mode_in;
        end
        default: begin
          if (armed_q && pend_hit) begin
            alarm_q <= 1'b1;
            fired_q <= 1'b1;
            armed_q <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cyc_alarm_timer.sv
module cyc_alarm_timer
  import cyc_alarm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter bit GE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sched_i,
  input  logic             cancel_i,
  input  logic             move_i,
  input  logic [WIDTH-1:0] target_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] count_o,
  output logic             alarm_o,
  output logic             armed_o,
  output logic             fired_o
);

  logic [WIDTH-1:0] count_q;
  match_mode_e      mode_sel;

  assign mode_sel = match_mode_e'(mode_i);

  cyc_free_counter #(.WIDTH(WIDTH)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .count_q (count_q)
  );

  cyc_alarm_ctrl #(.WIDTH(WIDTH), .GE_EN(GE_EN)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sched      (sched_i),
    .cancel     (cancel_i),
    .move       (move_i),
    .new_target (target_i),
    .new_mode   (mode_sel),
    .count      (count_q),
    .alarm_q    (alarm_o),
    .armed_q    (armed_o),
    .fired_q    (fired_o)
  );

  assign count_o = count_q;

endmodule

// File: rtl/cyc_alarm_timer_chk.sv
module cyc_alarm_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sched_i,
  input logic             cancel_i,
  input logic             move_i,
  input logic [WIDTH-1:0] count_o,
  input logic             alarm_o,
  input logic             armed_o,
  input logic             fired_o
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R11
  fired_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fired_o |=> fired_o);

  // R10
  pulse_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> (!armed_o && fired_o));

  // R12
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_o) |-> $past(armed_o || sched_i));

  // R7
  cancel_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_i |=> (!armed_o && !alarm_o));

  // R8
  move_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (move_i && armed_o && !cancel_i && !sched_i) |=> (armed_o && !alarm_o));

endmodule

bind cyc_alarm_timer cyc_alarm_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sched_i  (sched_i),
  .cancel_i (cancel_i),
  .move_i   (move_i),
  .count_o  (count_o),
  .alarm_o  (alarm_o),
  .armed_o  (armed_o),
  .fired_o  (fired_o)
);

// File: tb/test_cyc_alarm_timer.sv
module test_cyc_alarm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;
  localparam int MOD        = 1 << WIDTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sched_i = 1'b0;
  logic             cancel_i = 1'b0;
  logic             move_i = 1'b0;
  logic [WIDTH-1:0] target_i = '0;
  logic             mode_i = 1'b0;
  logic [WIDTH-1:0] count_o;
  logic             alarm_o;
  logic             armed_o;
  logic             fired_o;

  int checks = 0;
  int errors = 0;

  cyc_alarm_timer #(.WIDTH(WIDTH), .GE_EN(1'b1)) i_cyc_alarm_timer (
    .clk      (clk),
    .rst      (rst),
    .sched_i  (sched_i),
    .cancel_i (cancel_i),
    .move_i   (move_i),
    .target_i (target_i),
    .mode_i   (mode_i),
    .count_o  (count_o),
    .alarm_o  (alarm_o),
    .armed_o  (armed_o),
    .fired_o  (fired_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_count(input int v);
    for (int k = 0; k < 3*MOD; k++) begin
      if (int'(count_o) == v) break;
      tick();
    end
  endtask

  task automatic clear_req();
    sched_i = 1'b0; cancel_i = 1'b0; move_i = 1'b0;
  endtask

  // Ticks until a pulse appears; n = ticks taken, at = count seen with the pulse
  task automatic run_until_alarm(output int n, output int at);
    n = -1; at = -1;
    for (int k = 1; k <= 3*MOD; k++) begin
      tick();
      clear_req();
      if (alarm_o) begin n = k; at = int'(count_o); break; end
    end
  endtask

  task automatic count_alarms(input int cycles, output int seen);
    seen = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (alarm_o) seen++;
    end
  endtask

  task automatic schedule(input int tgt, input logic ge);
    target_i = WIDTH'(tgt); mode_i = ge; sched_i = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "alarm", int'(alarm_o), 0);
    chk("R1", "armed", int'(armed_o), 0);
    chk("R1", "fired", int'(fired_o), 0);
    rst = 1'b0;
    tick();
    chk("R2", "count after release", int'(count_o), 1);
  endtask

  task automatic t_wrap_count();
    wait_count(MOD-1);
    tick();
    chk("R2", "count wraps to zero", int'(count_o), 0);
    tick();
    chk("R2", "count after wrap", int'(count_o), 1);
  endtask

  task automatic t_cancel();
    int seen;
    wait_count(5);
    schedule(15, 1'b0);
    tick(); clear_req();
    chk("R12", "armed after schedule", int'(armed_o), 1);
    tick(); tick();
    cancel_i = 1'b1;
    tick(); clear_req();
    chk("R7", "armed after cancel", int'(armed_o), 0);
    count_alarms(MOD+20, seen);
    chk("R7", "pulses after cancel", seen, 0);
    chk("R11", "fired with no pulse", int'(fired_o), 0);
  endtask

  task automatic t_cancel_on_match();
    int seen;
    wait_count(5);
    schedule(15, 1'b0);
    tick(); clear_req();
    wait_count(15);
    cancel_i = 1'b1;
    tick(); clear_req();
    chk("R9", "alarm with cancel in match cycle", int'(alarm_o), 0);
    chk("R9", "armed after match-cycle cancel", int'(armed_o), 0);
    count_alarms(MOD+20, seen);
    chk("R9", "pulses after match-cycle cancel", seen, 0);
    // cancel beats a schedule that would match at once
    wait_count(60);
    schedule(60, 1'b0);
    cancel_i = 1'b1;
    tick(); clear_req();
    chk("R9", "alarm for cancel+schedule", int'(alarm_o), 0);
    chk("R9", "armed for cancel+schedule", int'(armed_o), 0);
  endtask

  task automatic t_move_idle();
    int seen;
    wait_count(5);
    target_i = 8'd20; mode_i = 1'b0; move_i = 1'b1;
    tick(); clear_req();
    chk("R8", "armed after idle move", int'(armed_o), 0);
    count_alarms(MOD+20, seen);
    chk("R8", "pulses after idle move", seen, 0);
    chk("R11", "fired still clear", int'(fired_o), 0);
  endtask

  task automatic t_eq_future();
    int n, at;
    wait_count(10);
    schedule(20, 1'b0);
    run_until_alarm(n, at);
    chk("R3", "cycles to pulse", n, 11);
    chk("R3", "count during pulse", at, 21);
    chk("R10", "armed during pulse", int'(armed_o), 0);
    chk("R11", "fired after pulse", int'(fired_o), 1);
    tick();
    chk("R10", "alarm one cycle later", int'(alarm_o), 0);
    chk("R10", "stays disarmed", int'(armed_o), 0);
  endtask

  task automatic t_immediate();
    int n, at;
    wait_count(77);
    schedule(77, 1'b0);
    run_until_alarm(n, at);
    chk("R4", "cycles to pulse for present target", n, 1);
    chk("R4", "count during pulse", at, 78);
  endtask

  task automatic t_passed();
    int n, at;
    wait_count(50);
    schedule(30, 1'b0);
    run_until_alarm(n, at);
    chk("R5", "cycles to pulse for passed target", n, ((30 - 50 + MOD) % MOD) + 1);
    chk("R5", "count during pulse", at, 31);
    wait_count(100);
    schedule(40, 1'b0);
    run_until_alarm(n, at);
    chk("R5", "equality mode waits for wrap", n, ((40 - 100 + MOD) % MOD) + 1);
  endtask

  task automatic t_ge();
    int n, at;
    wait_count(100);
    schedule(120, 1'b1);
    run_until_alarm(n, at);
    chk("R6", "cycles to pulse for threshold ahead", n, 21);
    wait_count(100);
    schedule(40, 1'b1);
    run_until_alarm(n, at);
    chk("R6", "threshold already passed fires at once", n, 1);
  endtask

  task automatic t_move();
    int n, at;
    wait_count(10);
    schedule(20, 1'b0);
    tick(); clear_req();
    tick(); tick();
    target_i = 8'd50; mode_i = 1'b0; move_i = 1'b1;
    tick(); clear_req();
    chk("R8", "armed after move", int'(armed_o), 1);
    run_until_alarm(n, at);
    chk("R8", "count during pulse after move", at, 51);
  endtask

  task automatic t_move_on_match();
    int n, at;
    wait_count(5);
    schedule(30, 1'b0);
    tick(); clear_req();
    wait_count(30);
    target_i = 8'd50; mode_i = 1'b0; move_i = 1'b1;
    tick(); clear_req();
    chk("R9", "alarm with move in match cycle", int'(alarm_o), 0);
    chk("R8", "armed after match-cycle move", int'(armed_o), 1);
    run_until_alarm(n, at);
    chk("R9", "pulse at moved target", at, 51);
    chk("R9", "cycles to moved pulse", n, 20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap_count();
    t_cancel();
    t_cancel_on_match();
    t_move_idle();
    t_eq_future();
    t_immediate();
    t_passed();
    t_ge();
    t_move();
    t_move_on_match();
    chk("R11", "fired stays high", int'(fired_o), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule